// File: doc/BRIEF.md
# Banked Host IO Register File

This block is the host-facing register file of a peripheral that sits behind a 16-byte IO window on an ISA-style bus. A strap input supplies the window's base. Each host strobe is compared against that base. A hit is served from one of three banks of sixteen byte-wide registers. Only the bank named by the bank-select field answers, and that field is reachable from every bank. The bus is either 8 or 16 bits wide, chosen per access. The block also drives the configuration outputs that the rest of the device reads: the live bank number, the transmit concurrent-processing enable and the receive concurrent-processing enable.

A four-state access sequencer handles every strobe. ST_IDLE waits for a strobe. A strobe that hits with the write line high commits its write on that edge and moves to ST_WHOLD. A strobe that hits with only the read line high moves to ST_READ, which drives the data bus until the read line drops. A strobe that misses moves to ST_SKIP and does nothing until both strobe lines are low. ST_WHOLD and ST_SKIP return to ST_IDLE once both strobes are low. ST_READ returns to ST_IDLE when the read line is low.

Top module: `iowin_regfile`

## Requirements
- R1: After reset every register reads 00h, the live bank is 0, the data bus is not driven, and both concurrent-processing enables are 0.
- R2: An access hits when io_addr[11:4] equals base_sel, with all 12 address bits compared. Addresses that differ only in bit 10 or bit 11 miss.
- R3: A miss never drives the bus: io_rdata_oe stays 0 and io_rdata stays 0000h. A miss also changes no register.
- R4: Register offset 0 holds the bank select in bits [1:0] and plain storage in bits [7:2], and it is the same register in every bank. Writing code 11 to bits [1:0] leaves the live bank unchanged.
- R5: Offsets 1 to 15 are separate per bank. Reads and writes touch only the live bank.
- R6: tx_concurrent equals bit 0 of bank 2, offset 1.
- R7: rx_concurrent is 1 exactly when bank 2's neighbour, bank 1, offset 7, is not 00h.
- R8: A 16-bit access (io_wide=1) at an even offset moves offset n on bits [7:0] and offset n+1 on bits [15:8].
- R9: A byte access, and a 16-bit access at an odd offset, moves only offset n on bits [7:0]. Read bits [15:8] are 00h.
- R10: One strobe commits exactly one write, using the data present on its first cycle. Read data is driven from the first edge after the read strobe until the read line drops.
- R11: When read and write strobes are high together on a hit, the access is taken as a write and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 8 | Window base, compared with io_addr[11:4] |
| io_addr | input | 12 | Host IO address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, 0000h when not driven |
| io_rdata_oe | output | 1 | Read data drive enable |
| cur_bank | output | 2 | Live bank number |
| tx_concurrent | output | 1 | Transmit concurrent-processing enable |
| rx_concurrent | output | 1 | Receive concurrent-processing enable |

## Verification
Some properties hold on every cycle, and the checker enforces those. The bus is never driven unless a read strobe was present one cycle earlier. The data bus is zero whenever it is not driven. The live bank is never the reserved code. Neither concurrent-processing enable changes except right after a write strobe. The bench scenarios cover what needs history to show: per-bank separation, the shared offset 0, the reserved code being ignored, lane placement in 16-bit mode, misses leaving stored values alone (including aliases in A10/A11), and the write data being taken from the first cycle of a held strobe.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
    localparam int NUM_BANKS = 3;
    localparam int NUM_REGS  = 16;
    localparam int BYTE_W    = 8;
    localparam int OFF_W     = $clog2(NUM_REGS);
    localparam int BANK_W    = 2;

    localparam logic [BANK_W-1:0] BANK_RSVD = 2'b11;

    localparam int TX_CTL_BANK = 2;
    localparam int TX_CTL_OFF  = 1;
    localparam int RX_CTL_BANK = 1;
    localparam int RX_CTL_OFF  = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WHOLD = 2'd2,
        ST_SKIP  = 2'd3
    } acc_state_t;
endpackage

// File: rtl/iowin_decode.sv
module iowin_decode #(
    parameter int ADDR_W     = 12,
    parameter bit EXT_DECODE = 1'b1
) (
    input  logic [ADDR_W-1:0]             io_addr,
    input  logic [ADDR_W-5:0]             base_sel,
    output logic                          hit,
    output logic [iowin_pkg::OFF_W-1:0]   off
);
    assign off = io_addr[iowin_pkg::OFF_W-1:0];

    generate
        if (EXT_DECODE) begin : g_full
            assign hit = (io_addr[ADDR_W-1:4] == base_sel);
        end else begin : g_pc_range
            logic unused_hi;
            assign unused_hi = ^{io_addr[ADDR_W-1:10], base_sel[ADDR_W-5:6]};
            assign hit = (io_addr[9:4] == base_sel[5:0]);
        end
    endgenerate
endmodule

// File: rtl/iowin_fsm.sv
module iowin_fsm
    import iowin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       io_rd,
    input  logic       io_wr,
    output acc_state_t state,
    output logic       wr_commit,
    output logic       rd_start
);
    acc_state_t state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (io_rd || io_wr) begin
                    if (!hit)       state_nxt = ST_SKIP;
                    else if (io_wr) state_nxt = ST_WHOLD;
                    else            state_nxt = ST_READ;
                end
            end
            ST_READ:  if (!io_rd) state_nxt = ST_IDLE;
            ST_WHOLD: if (!io_rd && !io_wr) state_nxt = ST_IDLE;
            ST_SKIP:  if (!io_rd && !io_wr) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_commit = (state == ST_IDLE) && hit && io_wr;
        rd_start  = (state == ST_IDLE) && hit && io_rd && !io_wr;
    end
endmodule

// File: rtl/iowin_bank_store.sv
module iowin_bank_store
    import iowin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_lo,
    input  logic                 we_hi,
    input  logic [OFF_W-1:0]     wr_off,
    input  logic [2*BYTE_W-1:0]  wdata,
    input  logic [OFF_W-1:0]     rd_off,
    output logic [BYTE_W-1:0]    rd_lo,
    output logic [BYTE_W-1:0]    rd_hi,
    output logic [BANK_W-1:0]    cur_bank,
    output logic                 tx_cc,
    output logic                 rx_cc
);
    logic [BYTE_W-1:0]   regs [NUM_BANKS][NUM_REGS];
    logic [BYTE_W-3:0]   ctl0_hi;
    logic [OFF_W-1:0]    wr_off_nxt;
    logic [OFF_W-1:0]    rd_off_nxt;

    assign wr_off_nxt = wr_off + OFF_W'(1);
    assign rd_off_nxt = rd_off + OFF_W'(1);

    // Offset 0: shared across banks, bank select in the low two bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bank <= '0;
            ctl0_hi  <= '0;
        end else if (we_lo && wr_off == '0) begin
            ctl0_hi <= wdata[BYTE_W-1:2];
            if (wdata[1:0] != BANK_RSVD && int'(wdata[1:0]) < NUM_BANKS)
                cur_bank <= wdata[1:0];
        end
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign regs[b][0] = '0;
            for (genvar r = 1; r < NUM_REGS; r++) begin : g_reg
                logic sel_lo, sel_hi;
                assign sel_lo = we_lo && (wr_off == OFF_W'(r));
                assign sel_hi = we_hi && (wr_off_nxt == OFF_W'(r));
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs[b][r] <= '0;
                    else if (cur_bank == BANK_W'(b)) begin
                        if (sel_lo)      regs[b][r] <= wdata[BYTE_W-1:0];
                        else if (sel_hi) regs[b][r] <= wdata[2*BYTE_W-1:BYTE_W];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        rd_lo = '0;
        rd_hi = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (cur_bank == BANK_W'(b)) begin
                rd_lo = regs[b][rd_off];
                rd_hi = regs[b][rd_off_nxt];
            end
        end
        if (rd_off == '0) rd_lo = {ctl0_hi, cur_bank};
    end

    assign tx_cc = regs[TX_CTL_BANK][TX_CTL_OFF][0];
    assign rx_cc = |regs[RX_CTL_BANK][RX_CTL_OFF];
endmodule

// File: rtl/iowin_regfile.sv
module iowin_regfile
    import iowin_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter bit EXT_DECODE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-5:0]    base_sel,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic                 io_wide,
    input  logic [2*BYTE_W-1:0]  io_wdata,
    output logic [2*BYTE_W-1:0]  io_rdata,
    output logic                 io_rdata_oe,
    output logic [BANK_W-1:0]    cur_bank,
    output logic                 tx_concurrent,
    output logic                 rx_concurrent
);
    logic             hit;
    logic [OFF_W-1:0] off;
    acc_state_t       state;
    logic             wr_commit, rd_start;
    logic [OFF_W-1:0] lat_off;
    logic             lat_pair;
    logic [BYTE_W-1:0] rd_lo, rd_hi;
    logic             pair_now;

    assign pair_now = io_wide && !io_addr[0];

    iowin_decode #(.ADDR_W(ADDR_W), .EXT_DECODE(EXT_DECODE)) u_decode (
        .io_addr  (io_addr),
        .base_sel (base_sel),
        .hit      (hit),
        .off      (off)
    );

    iowin_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .state     (state),
        .wr_commit (wr_commit),
        .rd_start  (rd_start)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_off  <= '0;
            lat_pair <= 1'b0;
        end else if (rd_start) begin
            lat_off  <= off;
            lat_pair <= pair_now;
        end
    end

    iowin_bank_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_lo    (wr_commit),
        .we_hi    (wr_commit && pair_now),
        .wr_off   (off),
        .wdata    (io_wdata),
        .rd_off   (lat_off),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .cur_bank (cur_bank),
        .tx_cc    (tx_concurrent),
        .rx_cc    (rx_concurrent)
    );

    always_comb begin
        io_rdata_oe = (state == ST_READ);
        io_rdata    = '0;
        if (io_rdata_oe)
            io_rdata = {(lat_pair ? rd_hi : {BYTE_W{1'b0}}), rd_lo};
    end
endmodule

// File: rtl/iowin_regfile_chk.sv
module iowin_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_rd,
    input logic        io_wr,
    input logic        io_rdata_oe,
    input logic [15:0] io_rdata,
    input logic [1:0]  cur_bank,
    input logic        tx_concurrent,
    input logic        rx_concurrent
);
    a_r10_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_oe |-> $past(io_rd));

    a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rdata_oe |-> io_rdata == 16'h0000);

    a_r11_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_rdata_oe) |-> !$past(io_wr));

    a_r4_bank_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cur_bank != 2'b11);

    a_r6_tx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_concurrent) |-> $past(io_wr));

    a_r7_rx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_concurrent) |-> $past(io_wr));
endmodule

bind iowin_regfile iowin_regfile_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_rd         (io_rd),
    .io_wr         (io_wr),
    .io_rdata_oe   (io_rdata_oe),
    .io_rdata      (io_rdata),
    .cur_bank      (cur_bank),
    .tx_concurrent (tx_concurrent),
    .rx_concurrent (rx_concurrent)
);

// File: tb/iowin_regfile_bench.sv
module iowin_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  base_sel = 8'h2A;
    logic [11:0] io_addr = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0, io_wide = 1'b0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        io_rdata_oe;
    logic [1:0]  cur_bank;
    logic        tx_concurrent, rx_concurrent;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    iowin_regfile u_iowin_regfile (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_wide(io_wide), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe), .cur_bank(cur_bank),
        .tx_concurrent(tx_concurrent), .rx_concurrent(rx_concurrent)
    );

    typedef struct {
        logic [15:0] exp_data;
        logic        exp_oe;
        string       req;
    } item_t;
    item_t sb_q[$];
    event  sample_ev;

    localparam logic [11:0] WIN = 12'h2A0;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected item and compares against the bus
    initial begin
        item_t it;
        forever begin
            @(sample_ev);
            it = sb_q.pop_front();
            check({it.req, " oe"}, {15'd0, io_rdata_oe}, {15'd0, it.exp_oe});
            check({it.req, " data"}, io_rdata, it.exp_data);
        end
    end

    task automatic wr(input logic [11:0] a, input logic wide, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wide = wide; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, input logic wide, input logic [15:0] exp,
                      input logic exp_oe, input string req);
        item_t it;
        @(negedge clk);
        io_addr = a; io_wide = wide; io_rd = 1'b1;
        @(negedge clk);
        it.exp_data = exp; it.exp_oe = exp_oe; it.req = req;
        sb_q.push_back(it);
        -> sample_ev;
        #0;
        io_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 oe", {15'd0, io_rdata_oe}, 16'd0);
        check("R1 bank", {14'd0, cur_bank}, 16'd0);
        check("R1 tx", {15'd0, tx_concurrent}, 16'd0);
        check("R1 rx", {15'd0, rx_concurrent}, 16'd0);
        rd(WIN + 12'd0, 1'b0, 16'h0000, 1'b1, "R1 reg0");
        rd(WIN + 12'd9, 1'b0, 16'h0000, 1'b1, "R1 reg9");
        // R2: hit and read back
        wr(WIN + 12'd5, 1'b0, 16'h005A);
        rd(WIN + 12'd5, 1'b0, 16'h005A, 1'b1, "R2 hit");
        // R5: bank 1 is separate
        wr(WIN + 12'd0, 1'b0, 16'h0001);
        check("R4 bank1", {14'd0, cur_bank}, 16'd1);
        rd(WIN + 12'd5, 1'b0, 16'h0000, 1'b1, "R5 bank1 reg5");
        rd(WIN + 12'd0, 1'b0, 16'h0001, 1'b1, "R4 reg0 shared");
        // R7: receive enable
        wr(WIN + 12'd7, 1'b0, 16'h0033);
        check("R7 rx on", {15'd0, rx_concurrent}, 16'd1);
        // R4: reserved code keeps bank, upper bits stored
        wr(WIN + 12'd0, 1'b0, 16'h00A7);
        check("R4 rsvd", {14'd0, cur_bank}, 16'd1);
        rd(WIN + 12'd0, 1'b0, 16'h00A5, 1'b1, "R4 reg0 after rsvd");
        // R6: transmit enable in bank 2
        wr(WIN + 12'd0, 1'b0, 16'h0002);
        wr(WIN + 12'd1, 1'b0, 16'h0001);
        check("R6 tx on", {15'd0, tx_concurrent}, 16'd1);
        wr(WIN + 12'd1, 1'b0, 16'h00FE);
        check("R6 tx off", {15'd0, tx_concurrent}, 16'd0);
        // R8/R9: 16-bit lanes
        wr(WIN + 12'd4, 1'b1, 16'hBEEF);
        rd(WIN + 12'd5, 1'b0, 16'h00BE, 1'b1, "R8 high lane");
        rd(WIN + 12'd4, 1'b1, 16'hBEEF, 1'b1, "R8 pair read");
        rd(WIN + 12'd5, 1'b1, 16'h00BE, 1'b1, "R9 odd wide");
        wr(WIN + 12'd9, 1'b1, 16'h1122);
        rd(WIN + 12'd9, 1'b0, 16'h0022, 1'b1, "R9 odd wide write");
        rd(WIN + 12'd10, 1'b0, 16'h0000, 1'b1, "R9 neighbour untouched");
        // R3/R2: misses
        wr(12'h6A5, 1'b0, 16'h0077);
        wr(12'h2B5, 1'b0, 16'h0077);
        rd(WIN + 12'd5, 1'b0, 16'h00BE, 1'b1, "R3 miss no write");
        rd(12'hAA5, 1'b0, 16'h0000, 1'b0, "R2 A11 alias miss");
        rd(12'h2B0, 1'b0, 16'h0000, 1'b0, "R3 miss no drive");
        // R10: held strobe commits first-cycle data once
        @(negedge clk);
        io_addr = WIN + 12'd3; io_wide = 1'b0; io_wdata = 16'h0044; io_wr = 1'b1;
        @(negedge clk);
        io_wdata = 16'h0099;
        repeat (2) @(negedge clk);
        io_wr = 1'b0;
        @(negedge clk);
        rd(WIN + 12'd3, 1'b0, 16'h0044, 1'b1, "R10 single commit");
        // R11: simultaneous read and write is a write
        @(negedge clk);
        io_addr = WIN + 12'd6; io_wdata = 16'h0066; io_wr = 1'b1; io_rd = 1'b1;
        @(negedge clk);
        check("R11 no drive", {15'd0, io_rdata_oe}, 16'd0);
        io_wr = 1'b0; io_rd = 1'b0;
        @(negedge clk);
        rd(WIN + 12'd6, 1'b0, 16'h0066, 1'b1, "R11 written");
        // R7: receive enable clears
        wr(WIN + 12'd0, 1'b0, 16'h0001);
        wr(WIN + 12'd7, 1'b0, 16'h0000);
        check("R7 rx off", {15'd0, rx_concurrent}, 16'd0);
        rd(WIN + 12'd5, 1'b0, 16'h0000, 1'b1, "R5 bank1 still clear");
        repeat (2) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule